// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits on the host side of a byte-wide parallel flash bus. It turns a single request into the full command sequence the device expects. A request is either a block erase or a single-byte program, and it carries an address and, for a program, one data byte. The block writes the command bytes in sequence. It waits for the device to report ready by polling the status register, reads the final status, and returns the device to read-array mode. It then reports the outcome with a one-cycle done pulse.

Requests use a ready/valid handshake and are taken only while the sequencer is idle. Status polling is bounded by a limit supplied with the request, so a device that never becomes ready cannot hang the sequencer. An erase inserts a fixed settle gap before the status command is issued; a program does not. Each completion reports the captured status byte, a timeout flag and an error flag derived from the status error bits.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is 1 only while idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. The operation, address, data and poll limit are captured on that cycle, and later changes on the request inputs have no effect until the next idle cycle.
- R2: An erase (`req_erase`=1) writes 0x50, 0x20 and 0xD0 on three consecutive cycles after acceptance, all at the request address.
- R3: After the 0xD0 write of an erase, the bus stays quiet for `SETTLE` cycles. The next cycle writes 0x70 at the request address.
- R4: A program (`req_erase`=0) writes 0x40 and then the data byte on the two cycles after acceptance. It writes 0x70 on the cycle after that, with no settle gap. All three writes go to the request address.
- R5: Starting the cycle after the 0x70 write, the block reads the request address once per cycle. It keeps reading while bit 7 of the read data is 0.
- R6: On the cycle after a poll read with bit 7 set, one more read is made, and its value becomes the reported status. On the cycle after that, 0xFF is written at the request address.
- R7: If the poll limit is reached without bit 7 set, 0xFF is written on the next cycle and the timeout flag is reported. The poll limit is the number of poll reads allowed, and a limit of 0 behaves as 1. In this case the reported status is the last polled value.
- R8: `done` is high for exactly one cycle, the cycle after the 0xFF write. The block is idle in that cycle, and `done_status`, `done_timeout` and `done_error` are valid in it.
- R9: `done_error` is 1 exactly when any of bits 5, 4, 3 or 1 of the reported status is set.
- R10: `fl_we` and `fl_re` are never high together. Neither is high except in the command, poll, final read and 0xFF cycles listed above.
- R11: After reset the block is idle with `req_ready`=1, `done`=0 and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_erase | input | 1 | 1 = block erase, 0 = byte program |
| req_addr | input | AW | Block or byte address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | LW | Maximum number of status poll reads |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | 8 | Flash bus write byte |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_rdata | input | 8 | Flash bus read byte, valid in a cycle with `fl_re` |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 8 | Final status byte |
| done_timeout | output | 1 | Polling ran out before ready |
| done_error | output | 1 | Status reported an error bit |

## Verification
The completion pulse of one operation and the acceptance of the next request can fall in the same cycle, because the done cycle is already idle. The bench provokes this by presenting a new request on the very cycle `done` is expected. It judges the outcome by checking the previous status, timeout and error values in that cycle, and then the full bus sequence of the new request from the following cycle on. A second run keeps `req_valid` high with random fields throughout a busy operation, to show that held-off requests leave the bus sequence untouched.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW     = 20,
  parameter int LW     = 16,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic [LW-1:0] poll_limit,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [7:0]    fl_rdata,
  output logic          done,
  output logic [7:0]    done_status,
  output logic          done_timeout,
  output logic          done_error
);

  typedef enum logic [3:0] {
    S_IDLE, S_C1, S_C2, S_C3, S_SETTLE, S_STAT, S_POLL, S_FINAL, S_RST
  } st_t;

  localparam logic [LW-1:0] SETTLE_LAST = (SETTLE > 0) ? LW'(SETTLE - 1) : '0;
  localparam logic [7:0]    ERR_MASK    = 8'h3A;

  st_t           st;
  logic          er_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [LW-1:0] lim_q, cnt;

  wire last_poll = ({1'b0, cnt} + 1'b1) >= {1'b0, lim_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      er_q         <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      lim_q        <= LW'(1);
      cnt          <= '0;
      done         <= 1'b0;
      done_status  <= '0;
      done_timeout <= 1'b0;
      done_error   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          er_q   <= req_erase;
          addr_q <= req_addr;
          data_q <= req_data;
          lim_q  <= (poll_limit == '0) ? LW'(1) : poll_limit;
          st     <= S_C1;
        end
        S_C1: st <= S_C2;
        S_C2: st <= er_q ? S_C3 : S_STAT;
        S_C3: begin
          cnt <= '0;
          st  <= (SETTLE > 0) ? S_SETTLE : S_STAT;
        end
        S_SETTLE: begin
          if (cnt == SETTLE_LAST) st <= S_STAT;
          else cnt <= cnt + 1'b1;
        end
        S_STAT: begin
          cnt <= '0;
          st  <= S_POLL;
        end
        S_POLL: begin
          if (fl_rdata[7]) st <= S_FINAL;
          else if (last_poll) begin
            done_status  <= fl_rdata;
            done_error   <= |(fl_rdata & ERR_MASK);
            done_timeout <= 1'b1;
            st           <= S_RST;
          end else cnt <= cnt + 1'b1;
        end
        S_FINAL: begin
          done_status  <= fl_rdata;
          done_error   <= |(fl_rdata & ERR_MASK);
          done_timeout <= 1'b0;
          st           <= S_RST;
        end
        S_RST: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign fl_addr   = addr_q;
  assign fl_we     = (st == S_C1) || (st == S_C2) || (st == S_C3) ||
                     (st == S_STAT) || (st == S_RST);
  assign fl_re     = (st == S_POLL) || (st == S_FINAL);

  always_comb begin
    case (st)
      S_C1:    fl_wdata = er_q ? 8'h50 : 8'h40;
      S_C2:    fl_wdata = er_q ? 8'h20 : data_q;
      S_C3:    fl_wdata = 8'hD0;
      S_STAT:  fl_wdata = 8'h70;
      S_RST:   fl_wdata = 8'hFF;
      default: fl_wdata = 8'h00;
    endcase
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  reset_write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RST) |=> done);

  // R1
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R1
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && st != S_RST) |=> $stable(fl_addr));

  // R2
  erase_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == 8'h20 && er_q) |=> (fl_we && fl_wdata == 8'hD0));

  // R7
  timeout_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> !done_status[7]);

  // R9
  error_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_error == |(done_status & ERR_MASK)));

endmodule

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  localparam int AW = 20, LW = 16, SETTLE = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic [LW-1:0] poll_limit = '0;
  logic          req_ready, fl_we, fl_re, done, done_timeout, done_error;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata, done_status;

  flash_seq #(.AW(AW), .LW(LW), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .poll_limit(poll_limit),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .done(done), .done_status(done_status),
    .done_timeout(done_timeout), .done_error(done_error));

  int checks = 0, errors = 0;

  // behavioural flash: busy for busy_n status reads, then ready
  int reads_total = 0, base = 0, busy_n = 0;
  logic [7:0] busy_val = 8'h00, ready_val = 8'h80;
  always @(posedge clk) if (fl_re) reads_total <= reads_total + 1;
  assign fl_rdata = ((reads_total - base) < busy_n) ? busy_val : ready_val;

  typedef struct { bit we; bit re; logic [7:0] d; string tag; } ent_t;
  ent_t q[$];

  bit pend = 0, p_to = 0, p_er = 0;
  logic [7:0] p_st = '0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // idle cycle: R1 ready, R10 quiet bus, R8 done with pending results
  task automatic check_idle_cycle(string tag);
    chk(req_ready == 1'b1, tag, "req_ready", req_ready, 1);
    chk(!fl_we && !fl_re, "R10", "bus strobes", {fl_we, fl_re}, 0);
    chk(done == pend, pend ? "R8" : tag, "done", done, pend);
    if (pend) begin
      chk(done_status == p_st, p_to ? "R7" : "R6", "status", done_status, p_st);
      chk(done_timeout == p_to, "R7", "timeout", done_timeout, p_to);
      chk(done_error == p_er, "R9", "error", done_error, p_er);
    end
    pend = 0;
  endtask

  task automatic push(bit we, bit re, logic [7:0] d, string tag);
    ent_t e;
    e.we = we; e.re = re; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run_op(bit er, logic [AW-1:0] a, logic [7:0] d, int lim, int busy,
                        logic [7:0] bval, logic [7:0] rval, bit garble, string tag);
    int le;
    int npoll;
    bit to;
    le = (lim == 0) ? 1 : lim;
    @(negedge clk);
    req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
    poll_limit = LW'(lim);
    base = reads_total; busy_n = busy; busy_val = bval; ready_val = rval;
    check_idle_cycle(tag);
    if (er) begin
      push(1, 0, 8'h50, "R2"); push(1, 0, 8'h20, "R2"); push(1, 0, 8'hD0, "R2");
      for (int i = 0; i < SETTLE; i++) push(0, 0, 8'h00, "R3");
      push(1, 0, 8'h70, "R3");
    end else begin
      push(1, 0, 8'h40, "R4"); push(1, 0, d, "R4"); push(1, 0, 8'h70, "R4");
    end
    to = (busy >= le);
    npoll = to ? le : busy + 1;
    for (int i = 0; i < npoll; i++) push(0, 1, 8'h00, "R5");
    if (!to) push(0, 1, 8'h00, "R6");
    push(1, 0, 8'hFF, to ? "R7" : "R6");
    while (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      @(negedge clk);
      if (garble) begin
        req_valid = 1'b1; req_erase = 1'($urandom); req_addr = AW'($urandom);
        req_data = 8'($urandom); poll_limit = LW'($urandom);
      end else req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1", "req_ready busy", req_ready, 0);
      chk(done == 1'b0, "R8", "done busy", done, 0);
      chk(fl_we == e.we && fl_re == e.re, e.tag, "strobes", {fl_we, fl_re}, {e.we, e.re});
      if (e.we || e.re) chk(fl_addr == a, e.tag, "address", int'(fl_addr), int'(a));
      if (e.we) chk(fl_wdata == e.d, e.tag, "write byte", fl_wdata, e.d);
    end
    pend = 1;
    p_to = to;
    p_st = to ? bval : rval;
    p_er = |(p_st & 8'h3A);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    req_valid = 1'b0;
    check_idle_cycle(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_check("R11");
    idle_check("R11");
    // R2 R3 R5 R6: erase, ready after three busy reads
    run_op(1, 20'h30000, 8'h00, 10, 3, 8'h00, 8'h80, 0, "R2");
    idle_check("R8");
    // R4: program, device ready at once
    run_op(0, 20'h12345, 8'h5A, 10, 0, 8'h00, 8'h80, 0, "R4");
    idle_check("R8");
    // R9: program data 0xFF, status with bit 4
    run_op(0, 20'h00001, 8'hFF, 10, 2, 8'h00, 8'h90, 0, "R9");
    idle_check("R8");
    // R9: erase, status bits 5 and 1
    run_op(1, 20'hF0000, 8'h00, 10, 1, 8'h00, 8'hA2, 0, "R9");
    idle_check("R8");
    // R7: timeout, last polled value carries bit 5
    run_op(1, 20'h20000, 8'h00, 3, 10, 8'h20, 8'h80, 0, "R7");
    idle_check("R7");
    // R7: limit 0 acts as one read
    run_op(0, 20'h0ABCD, 8'h11, 0, 5, 8'h00, 8'h80, 0, "R7");
    idle_check("R7");
    // R7 boundary: ready on the last permitted read
    run_op(0, 20'h0ABCE, 8'h22, 4, 3, 8'h00, 8'h88, 0, "R7");
    idle_check("R9");
    // R1: held-off requests during busy, then chained acceptance on done
    run_op(0, 20'h55555, 8'hC3, 6, 2, 8'h00, 8'h80, 1, "R1");
    run_op(1, 20'hAAAAA, 8'h00, 6, 1, 8'h00, 8'h80, 1, "R1");
    run_op(0, 20'h00100, 8'h01, 2, 0, 8'h00, 8'hC0, 0, "R1");
    idle_check("R8");
    idle_check("R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule